// File: doc/BRIEF.md
# DMA Completion Record Read Port

This block sits between a DMA engine and a host bus. Each time the engine finishes a transfer it pushes one completion record into a small FIFO. A record holds the number of bytes moved, an 8-bit error code and an early-termination flag. The host reads the oldest record through a read-only, byte-enabled slave port. The port shows that record as two 32-bit words: the byte count in word 0 and the status in word 1.

A record leaves the FIFO only when a host read covers the most significant byte lane of the status word. All other reads return the head record and leave it in place. A host can therefore read the count first and the low status lanes next, in any order, and read the top status lane last. That last read retires the record. This keeps the count and status of one record together for masters of either byte order. The engine side uses a valid/ready handshake. Ready drops when the FIFO is full, unless a pop happens in the same cycle.

Top module: `dma_cpl_rdport`

## Requirements
- R1: After reset, fifoEmpty is 1, fifoFull is 0, pushReady is 1, rdValid is 0 and rdData is 0.
- R2: A record is accepted on a clock edge where pushValid and pushReady are both 1. pushReady is 0 when DEPTH records are held and no pop happens in that cycle. fifoFull is 1 exactly when DEPTH records are held, and fifoEmpty is 1 exactly when none are held.
- R3: A read (rdStrobe 1, wrStrobe 0) returns data one cycle later with rdValid 1. With rdWordSel 0 the data is the head record's byte count. With rdWordSel 1 the data has the error code in bits 7:0, the early-termination flag in bit 8, and bits 31:9 zero.
- R4: The head record is removed at the end of a read only if rdWordSel is 1, rdByteEn bit 3 is 1 and the FIFO is not empty. Any other read leaves the head and the occupancy unchanged.
- R5: A read while the FIFO is empty returns 0 and does not change the occupancy.
- R6: Byte lane i of rdData (bits 8i+7 down to 8i) is zero when rdByteEn bit i is 0.
- R7: An access with wrStrobe 1 is ignored. It produces no rdValid and no pop, even if rdStrobe is also 1.
- R8: A push and a pop in the same cycle on a full FIFO are both accepted, and the FIFO stays full.
- R9: Records are read out in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Engine offers a completion record |
| pushCount | input | 32 | Transferred-byte count of the offered record |
| pushErr | input | 8 | Error code of the offered record |
| pushEarly | input | 1 | Early-termination flag of the offered record |
| pushReady | output | 1 | FIFO can take the offered record this cycle |
| rdStrobe | input | 1 | Host read access |
| wrStrobe | input | 1 | Host write access (ignored) |
| rdWordSel | input | 1 | 0 selects the count word, 1 selects the status word |
| rdByteEn | input | 4 | Byte lanes of the access |
| rdData | output | 32 | Read data, one cycle after the access |
| rdValid | output | 1 | rdData holds the result of a read |
| fifoEmpty | output | 1 | No record held |
| fifoFull | output | 1 | DEPTH records held |

## Verification
The assertions assume the host issues at most one access per cycle and treat an access that has both strobes high as a write. They also assume the engine's record fields are stable while pushValid is high. The stimulus drives every input once per cycle, half a period away from the sampling edge. It mixes random push, read and write cycles with random lanes and word selects, and it often leaves the top status lane out of the byte enables. This lets the FIFO fill, drain and sit at full during a simultaneous push and pop without breaking those assumptions.

// File: rtl/dma_cpl_pkg.sv
package dma_cpl_pkg;
  localparam int COUNT_W  = 32;
  localparam int ERR_W    = 8;
  localparam int BUS_W    = 32;
  localparam int LANES    = BUS_W / 8;
  localparam int POP_LANE = LANES - 1;

  typedef struct packed {
    logic [COUNT_W-1:0] byteCount;
    logic [ERR_W-1:0]   errCode;
    logic               earlyTerm;
  } cplRec_t;

  typedef struct packed {
    logic             doPush;
    logic             doPop;
    logic             doRead;
    logic             wordSel;
    logic [LANES-1:0] laneMask;
    logic             headValid;
  } ctlStrobe_t;
endpackage

// File: rtl/dma_cpl_ctrl.sv
module dma_cpl_ctrl
  import dma_cpl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             rdStrobe,
  input  logic             wrStrobe,
  input  logic             rdWordSel,
  input  logic [LANES-1:0] rdByteEn,
  output logic             pushReady,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output ctlStrobe_t       strobe
);
  logic [OCC_W-1:0] occupancy;
  logic             isRead;
  logic             popReq;
  logic             pushAcc;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    isRead    = rdStrobe && !wrStrobe;
    fifoEmpty = (occupancy == '0);
    fifoFull  = (occupancy == OCC_W'(DEPTH));
    popReq    = isRead && rdWordSel && rdByteEn[POP_LANE] && !fifoEmpty;
    pushReady = !fifoFull || popReq;
    pushAcc   = pushValid && pushReady;

    strobe.doPush    = pushAcc;
    strobe.doPop     = popReq;
    strobe.doRead    = isRead;
    strobe.wordSel   = rdWordSel;
    strobe.laneMask  = rdByteEn;
    strobe.headValid = !fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupancy <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
    end else begin
      if (pushAcc) wrPtr <= bump(wrPtr);
      if (popReq)  rdPtr <= bump(rdPtr);
      case ({pushAcc, popReq})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= OCC_W'(DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !popReq) |-> !pushReady); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |=> (occupancy <= 1)); // R5
  AST_LANE_NOPOP: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && !(rdWordSel && rdByteEn[POP_LANE]) && !pushValid)
      |=> occupancy == $past(occupancy)); // R4
  AST_WRITE_NOPOP: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !pushValid) |=> occupancy == $past(occupancy)); // R7
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && popReq && pushValid) |=> fifoFull); // R8
endmodule

// File: rtl/dma_cpl_data.sv
module dma_cpl_data
  import dma_cpl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [COUNT_W-1:0] pushCount,
  input  logic [ERR_W-1:0]   pushErr,
  input  logic               pushEarly,
  output logic [BUS_W-1:0]   rdData,
  output logic               rdValid
);
  cplRec_t          store [DEPTH];
  cplRec_t          head;
  logic [BUS_W-1:0] wordSelData;
  logic [BUS_W-1:0] laneData;

  always_ff @(posedge clk) begin
    if (strobe.doPush) begin
      store[wrPtr].byteCount <= pushCount;
      store[wrPtr].errCode   <= pushErr;
      store[wrPtr].earlyTerm <= pushEarly;
    end
  end

  always_comb begin
    head        = store[rdPtr];
    wordSelData = strobe.wordSel
                ? {{(BUS_W - ERR_W - 1){1'b0}}, head.earlyTerm, head.errCode}
                : BUS_W'(head.byteCount);
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign laneData[lane*8 +: 8] = strobe.laneMask[lane] ? wordSelData[lane*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.doRead;
      rdData  <= (strobe.doRead && strobe.headValid) ? laneData : '0;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRead |=> rdValid); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRead && !strobe.headValid) |=> rdData == '0); // R5
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRead && strobe.wordSel) |=> rdData[BUS_W-1:ERR_W+1] == '0); // R3
  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRead && !strobe.laneMask[0]) |=> rdData[7:0] == 8'h00); // R6
endmodule

// File: rtl/dma_cpl_rdport.sv
module dma_cpl_rdport
  import dma_cpl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  logic [31:0] pushCount,
  input  logic [7:0]  pushErr,
  input  logic        pushEarly,
  output logic        pushReady,
  input  logic        rdStrobe,
  input  logic        wrStrobe,
  input  logic        rdWordSel,
  input  logic [3:0]  rdByteEn,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        fifoEmpty,
  output logic        fifoFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctlStrobe_t       strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  dma_cpl_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pushValid (pushValid),
    .rdStrobe  (rdStrobe),
    .wrStrobe  (wrStrobe),
    .rdWordSel (rdWordSel),
    .rdByteEn  (rdByteEn),
    .pushReady (pushReady),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .strobe    (strobe)
  );

  dma_cpl_data #(.DEPTH(DEPTH)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .pushCount (pushCount),
    .pushErr   (pushErr),
    .pushEarly (pushEarly),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );
endmodule

// File: tb/dma_cpl_rdport_tb.sv
`timescale 1ns/1ps
module dma_cpl_rdport_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0;
  logic [31:0] pushCount = '0;
  logic [7:0]  pushErr = '0;
  logic        pushEarly = 1'b0;
  logic        pushReady;
  logic        rdStrobe = 1'b0;
  logic        wrStrobe = 1'b0;
  logic        rdWordSel = 1'b0;
  logic [3:0]  rdByteEn = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        fifoEmpty;
  logic        fifoFull;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [40:0] model [$];

  always #2.5 clk = ~clk;

  dma_cpl_rdport #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input bit sel, input logic [3:0] be);
    logic [31:0] w;
    logic [40:0] r;
    if (model.size() == 0) return 32'h0;
    r = model[0];
    w = sel ? {23'h0, r[0], r[8:1]} : r[40:9];
    for (int i = 0; i < 4; i++) if (!be[i]) w[i*8 +: 8] = 8'h00;
    return w;
  endfunction

  task automatic step(input bit pv, input logic [31:0] pc, input logic [7:0] pe, input bit pt,
                      input bit rs, input bit wr, input bit ws, input logic [3:0] be, input string tag);
    bit isRd, pop, expRdy;
    logic [31:0] expD;
    pushValid = pv; pushCount = pc; pushErr = pe; pushEarly = pt;
    rdStrobe = rs; wrStrobe = wr; rdWordSel = ws; rdByteEn = be;
    #1;
    isRd = rs && !wr;
    pop = isRd && ws && be[3] && model.size() > 0;
    expRdy = (model.size() < DEPTH) || pop;
    expD = expWord(ws, be);
    check(tag, "pushReady", 32'(pushReady), 32'(expRdy));
    @(negedge clk);
    check(tag, "rdValid", 32'(rdValid), 32'(isRd));
    if (isRd) check(tag, "rdData", rdData, expD);
    if (pop) void'(model.pop_front());
    if (pv && expRdy) model.push_back({pc, pe, pt});
    check(tag, "fifoEmpty", 32'(fifoEmpty), 32'(model.size() == 0));
    check(tag, "fifoFull", 32'(fifoFull), 32'(model.size() == DEPTH));
    pushValid = 1'b0; rdStrobe = 1'b0; wrStrobe = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1", "fifoEmpty", 32'(fifoEmpty), 32'd1);
    check("R1", "fifoFull", 32'(fifoFull), 32'd0);
    check("R1", "rdValid", 32'(rdValid), 32'd0);
    check("R1", "rdData", rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "pushReady", 32'(pushReady), 32'd1);

    step(0, 0, 0, 0, 1, 0, 1, 4'hF, "R5");
    step(0, 0, 0, 0, 1, 0, 0, 4'hF, "R5");
    step(1, 32'h0000_1234, 8'hA5, 1, 0, 0, 0, 4'h0, "R2");
    step(1, 32'hCAFE_0002, 8'h3C, 0, 0, 0, 0, 4'h0, "R2");
    step(1, 32'h0000_0003, 8'h00, 1, 0, 0, 0, 4'h0, "R2");
    step(0, 0, 0, 0, 1, 0, 0, 4'hF, "R3");
    step(0, 0, 0, 0, 1, 0, 1, 4'h7, "R4");
    step(0, 0, 0, 0, 1, 0, 0, 4'hF, "R4");
    step(0, 0, 0, 0, 1, 0, 1, 4'h3, "R6");
    step(0, 0, 0, 0, 1, 0, 0, 4'h5, "R6");
    step(0, 0, 0, 0, 1, 1, 1, 4'hF, "R7");
    step(0, 0, 0, 0, 0, 1, 1, 4'hF, "R7");
    step(0, 0, 0, 0, 1, 0, 1, 4'h8, "R4");
    step(0, 0, 0, 0, 1, 0, 0, 4'hF, "R9");
    step(0, 0, 0, 0, 1, 0, 1, 4'hF, "R9");
    for (int i = 0; i < DEPTH + 1; i++)
      step(1, $urandom, 8'($urandom), 1'($urandom), 0, 0, 0, 4'h0, "R2");
    step(1, 32'hDEAD_BEEF, 8'h77, 1, 1, 0, 1, 4'hF, "R8");
    step(1, 32'h0BAD_F00D, 8'h11, 0, 1, 0, 1, 4'hC, "R8");
    for (int i = 0; i < DEPTH + 1; i++) begin
      step(0, 0, 0, 0, 1, 0, 1, 4'h7, "R9");
      step(0, 0, 0, 0, 1, 0, 0, 4'hF, "R9");
      step(0, 0, 0, 0, 1, 0, 1, 4'h8, "R9");
    end
    for (int i = 0; i < 4000; i++) begin
      bit pv, rs, wr, ws;
      pv = ($urandom % 3) != 0;
      rs = ($urandom % 2) == 0;
      wr = ($urandom % 8) == 0;
      ws = ($urandom % 2) == 0;
      step(pv, $urandom, 8'($urandom), 1'($urandom), rs, wr, ws, 4'($urandom), "R9");
    end
    finishRun();
  end
endmodule